// File: doc/BRIEF.md
# Hypercube Dimension-Order Cut-Through Router

This block is the switching element of one node in a binary hypercube of 2^D nodes. It has one incoming and one outgoing link per cube dimension, plus a local inject input and a local eject output. Every link direction is its own valid/ready channel, so traffic on one link never waits for traffic on an unrelated link.

A packet is a run of flits. The destination node address sits in the low D bits of the first flit (the head). The final flit has its `last` bit set, and a single-flit packet has `last` set on its head. The router XORs its own address with the destination. If the result is zero the packet leaves on the eject port. If not, it leaves on the dimension of the lowest set bit of the XOR, so address bits are corrected from dimension 0 upward and a route never exceeds D hops.

Forwarding is cut-through. The head is decoded in the cycle it arrives and appears on the chosen output in that same cycle, and the body follows flit by flit. An output stays bound to one input from head to tail. When several heads compete for a free output, the router picks among them in round-robin order. A blocked output back-pressures its input and never drops a flit.

Top module: `hc_router`

## Requirements
- R1: When a head's destination address (data bits [D-1:0]) equals `node_id`, the packet leaves on the eject output, which is port index D.
- R2: When the destination differs from `node_id`, the packet leaves on output port k, where k is the lowest bit position at which the two addresses differ.
- R3: A head flit appears unchanged on its chosen output in the same cycle it is offered on an input (zero cycles of added latency), and body flits follow in the same way.
- R4: Once an output has accepted a head that is not a tail, it carries only that input's flits until the flit with `last` set has been accepted. Other inputs requesting that output see `in_ready` low during that time.
- R5: Among heads competing for a free output, the grant starts searching at the input after the previous winner and wraps around (round-robin). With a pointer starting at input 0 after reset, inputs 0 and 2 competing after a win by input 1 go to input 2 first.
- R6: While an output shows valid and its `out_ready` is low, the offering input sees `in_ready` low, and the output keeps the same flit and the same owner until the flit is accepted. A head arriving later from another input does not displace it.
- R7: Packets from different inputs bound for different outputs are forwarded in the same cycle.
- R8: During reset and after it, with no input valid, every `out_valid` and every `in_ready` is low.
- R9: A single-flit packet (head with `last` set) releases its output as soon as it is accepted, so the output is free for another input in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_id | input | D | This node's cube address |
| in_valid | input | D+1 | Flit offered per input port (index D is local inject) |
| in_last | input | D+1 | Offered flit ends its packet |
| in_data | input | (D+1)*W | Flit payload per input, port p at bits [p*W +: W] |
| in_ready | output | D+1 | Input flit accepted this cycle when valid |
| out_valid | output | D+1 | Flit presented per output port (index D is local eject) |
| out_last | output | D+1 | Presented flit ends its packet |
| out_data | output | (D+1)*W | Flit payload per output, port p at bits [p*W +: W] |
| out_ready | input | D+1 | Downstream accepts the presented flit |

## Verification
If the per-input packet state were wrong, body flits would leave on a port other than the one their head took, and this would show on the second flit of the packet. If an output's ownership state were corrupt, a flit from a second input would appear in the middle of a packet, or a stalled flit would be swapped for another one. Both cases show on `out_data` within one cycle of the fault. A wrong round-robin pointer shows only when two heads compete, as the wrong input winning in the cycle of the contest. All of these faults are visible at the ports within one or two cycles.

// File: rtl/hc_pkg.sv
package hc_pkg;
  // per-input packet tracking
  typedef enum logic {IN_IDLE = 1'b0, IN_BODY = 1'b1} in_state_e;
  // per-output ownership
  typedef enum logic {OUT_OPEN = 1'b0, OUT_HELD = 1'b1} out_state_e;
endpackage

// File: rtl/hc_route_calc.sv
module hc_route_calc #(
  parameter int D = 3
) (
  input  logic [D-1:0] node,
  input  logic [D-1:0] dest,
  output logic [D:0]   port_oh
);
  logic [D-1:0] diff;
  logic [D-1:0] low_bit;

  always_comb begin
    diff    = node ^ dest;
    // isolate the lowest differing dimension
    low_bit = diff & (~diff + 1'b1);
    port_oh = {(diff == '0), low_bit};
  end
endmodule

// File: rtl/hc_in_ctrl.sv
module hc_in_ctrl #(
  parameter int D = 3,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [D-1:0] node,
  input  logic         valid,
  input  logic         last,
  input  logic [W-1:0] data,
  input  logic         xfer,
  output logic [D:0]   req
);
  import hc_pkg::*;

  in_state_e  state_q, state_d;
  logic [D:0] tgt_q, tgt_d;
  logic       tgt_en;
  logic [D:0] head_port;

  hc_route_calc #(.D(D)) i_route (
    .node    (node),
    .dest    (data[D-1:0]),
    .port_oh (head_port)
  );

  always_comb begin
    if (!valid)               req = '0;
    else if (state_q == IN_BODY) req = tgt_q;
    else                      req = head_port;
  end

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    tgt_en  = 1'b0;
    if (xfer) begin
      if (last) begin
        state_d = IN_IDLE;
      end else if (state_q == IN_IDLE) begin
        state_d = IN_BODY;
        tgt_d   = head_port;
        tgt_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IN_IDLE;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (tgt_en) tgt_q <= tgt_d;
    end
  end

  // R7: one packet targets at most one output at a time
  a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));

  // R4: body flits keep the port chosen by the head
  a_r4_body_port_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last && state_q == IN_IDLE) |=> (!valid || req == $past(req)));
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         last_sel,
  input  logic         out_ready,
  output logic [N-1:0] gnt,
  output logic         active,
  output logic         fire
);
  import hc_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  out_state_e    state_q, state_d;
  logic [IW-1:0] owner_q, owner_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic          win_found;
  logic [IW-1:0] win_idx;

  // rotating search starting at the pointer
  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!win_found && req[j]) begin
        win_found = 1'b1;
        win_idx   = IW'(j);
      end
    end
  end

  always_comb begin
    gnt = '0;
    if (state_q == OUT_HELD)  gnt[owner_q] = 1'b1;
    else if (win_found)       gnt[win_idx] = 1'b1;
    active = |(gnt & req);
    fire   = active && out_ready;
  end

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    if (state_q == OUT_HELD) begin
      if (fire && last_sel) state_d = OUT_OPEN;
    end else if (win_found) begin
      // hold the winner until its tail, or until a stalled flit goes out
      owner_d = win_idx;
      state_d = (fire && last_sel) ? OUT_OPEN : OUT_HELD;
      ptr_en  = 1'b1;
      ptr_d   = (int'(win_idx) == N - 1) ? '0 : win_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OUT_OPEN;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  // R5: never more than one input granted
  a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R4: an owned output keeps its owner until the tail leaves
  a_r4_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(fire && last_sel)) |=> (gnt == $past(gnt)));
endmodule

// File: rtl/hc_router.sv
module hc_router #(
  parameter int D = 3,
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [D-1:0]     node_id,
  input  logic [D:0]       in_valid,
  input  logic [D:0]       in_last,
  input  logic [(D+1)*W-1:0] in_data,
  output logic [D:0]       in_ready,
  output logic [D:0]       out_valid,
  output logic [D:0]       out_last,
  output logic [(D+1)*W-1:0] out_data,
  input  logic [D:0]       out_ready
);
  localparam int P = D + 1;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [P-1:0] req_in  [P];
  logic [P-1:0] req_out [P];
  logic [P-1:0] gnt_out [P];
  logic [P-1:0] last_sel;
  logic [P-1:0] active;
  logic [P-1:0] fire;
  logic [P-1:0] xfer_in;

  assign xfer_in = in_valid & in_ready;

  for (genvar i = 0; i < P; i++) begin : g_in
    hc_in_ctrl #(.D(D), .W(W)) i_in (
      .clk   (clk),
      .rst_n (rst_sync_q),
      .node  (node_id),
      .valid (in_valid[i]),
      .last  (in_last[i]),
      .data  (in_data[i*W +: W]),
      .xfer  (xfer_in[i]),
      .req   (req_in[i])
    );
  end

  always_comb begin
    for (int o = 0; o < P; o++)
      for (int i = 0; i < P; i++)
        req_out[o][i] = req_in[i][o];
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    hc_rr_arb #(.N(P)) i_arb (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .req       (req_out[o]),
      .last_sel  (last_sel[o]),
      .out_ready (out_ready[o]),
      .gnt       (gnt_out[o]),
      .active    (active[o]),
      .fire      (fire[o])
    );
  end

  // crossbar
  always_comb begin
    out_data = '0;
    out_last = '0;
    last_sel = '0;
    in_ready = '0;
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < P; i++) begin
        if (gnt_out[o][i]) begin
          out_data[o*W +: W] = in_data[i*W +: W];
          last_sel[o]        = in_last[i];
          out_last[o]        = in_last[i] && req_out[o][i];
        end
        if (gnt_out[o][i] && req_out[o][i] && out_ready[o])
          in_ready[i] = 1'b1;
      end
    end
    out_valid = active;
  end

  // R6: a stalled flit stays put until taken
  for (genvar o = 0; o < P; o++) begin : g_chk
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_sync_q)
      (out_valid[o] && !out_ready[o]) |=>
        (out_valid[o] && $stable(out_data[o*W +: W])));
  end

  // R6: accepted input flits always leave through an output in the same cycle
  a_r6_no_drop: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones(xfer_in) == $countones(fire));
endmodule

// File: tb/test_hc_router.sv
module test_hc_router;
  localparam int D = 3;
  localparam int W = 16;
  localparam int P = D + 1;

  logic             clk;
  logic             rst_n;
  logic [D-1:0]     node_id;
  logic [P-1:0]     in_valid, in_last, in_ready;
  logic [P*W-1:0]   in_data;
  logic [P-1:0]     out_valid, out_last, out_ready;
  logic [P*W-1:0]   out_data;

  int checks = 0;
  int errors = 0;

  hc_router #(.D(D), .W(W)) i_hc_router (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .in_valid(in_valid), .in_last(in_last), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last),
    .out_data(out_data), .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {node[2:0], inport[1:0], dest[2:0], expected outport[1:0]}
  localparam logic [9:0] VEC [10] = '{
    {3'd3, 2'd0, 3'd3, 2'd3},   // R1 same address -> eject
    {3'd0, 2'd3, 3'd0, 2'd3},   // R1
    {3'd5, 2'd3, 3'd2, 2'd0},   // R2 xor 111 -> dim0
    {3'd6, 2'd1, 3'd0, 2'd1},   // R2 xor 110 -> dim1
    {3'd0, 2'd2, 3'd4, 2'd2},   // R2 xor 100 -> dim2
    {3'd7, 2'd3, 3'd3, 2'd2},   // R2 xor 100 -> dim2
    {3'd1, 2'd0, 3'd7, 2'd1},   // R2 xor 110 -> dim1
    {3'd2, 2'd1, 3'd5, 2'd0},   // R2 xor 111 -> dim0
    {3'd4, 2'd2, 3'd2, 2'd1},   // R2 xor 110 -> dim1
    {3'd6, 2'd0, 3'd6, 2'd3}    // R1
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = '0;
    in_last  = '0;
    in_data  = '0;
  endtask

  task automatic offer(input int p, input logic [W-1:0] d, input bit lst);
    in_valid[p]       = 1'b1;
    in_last[p]        = lst;
    in_data[p*W +: W] = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    out_ready = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    node_id = '0;
    out_ready = '1;
    idle_inputs();
    repeat (2) @(negedge clk);
    #2;
    check(out_valid == '0, "R8", "out_valid in reset", out_valid, 0);
    check(in_ready == '0, "R8", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == '0 && in_ready == '0, "R8", "idle after reset",
          {in_ready, out_valid}, 0);

    // table walk: single-flit packets
    for (int v = 0; v < 10; v++) begin
      logic [2:0] nd, ds;
      logic [1:0] ip, ep;
      logic [W-1:0] fl;
      {nd, ip, ds, ep} = VEC[v];
      @(negedge clk);
      idle_inputs();
      node_id = nd;
      fl = {8'hA0 + 8'(v), 5'd0, ds};
      offer(ip, fl, 1'b1);
      #2;
      check(out_valid == (4'b1 << ep), (ep == 2'd3) ? "R1" : "R2",
            "output select", out_valid, 4'b1 << ep);
      check(out_data[ep*W +: W] == fl && out_last[ep], "R3",
            "head same cycle", out_data[ep*W +: W], fl);
      check(in_ready[ip], "R3", "input accepted", in_ready, 4'b1 << ip);
    end
    @(negedge clk);
    idle_inputs();

    // R4/R5/R9 on eject output, node 0
    do_reset();
    node_id = 3'd0;
    offer(0, 16'h1100, 1'b0);
    offer(1, 16'h2200, 1'b0);
    #2;
    check(out_data[3*W +: W] == 16'h1100 && in_ready == 4'b0001, "R4",
          "in0 wins head", out_data[3*W +: W], 16'h1100);
    @(negedge clk);
    offer(0, 16'h1101, 1'b0);
    #2;
    check(out_data[3*W +: W] == 16'h1101 && !in_ready[1], "R4",
          "body keeps owner", out_data[3*W +: W], 16'h1101);
    @(negedge clk);
    offer(0, 16'h1102, 1'b1);
    #2;
    check(out_data[3*W +: W] == 16'h1102 && out_last[3] && !in_ready[1], "R4",
          "tail keeps owner", out_data[3*W +: W], 16'h1102);
    @(negedge clk);
    in_valid[0] = 1'b0;
    offer(1, 16'h2200, 1'b1);
    #2;
    check(out_data[3*W +: W] == 16'h2200 && in_ready[1], "R4",
          "released after tail", out_data[3*W +: W], 16'h2200);
    @(negedge clk);
    idle_inputs();
    offer(0, 16'h3300, 1'b1);
    offer(2, 16'h4400, 1'b1);
    #2;
    check(out_data[3*W +: W] == 16'h4400 && in_ready == 4'b0100, "R5",
          "rotation picks in2", out_data[3*W +: W], 16'h4400);
    @(negedge clk);
    in_valid[2] = 1'b0;
    #2;
    check(out_data[3*W +: W] == 16'h3300 && in_ready[0], "R9",
          "single flit frees output", out_data[3*W +: W], 16'h3300);

    // R6 stall, then a competing head arrives
    @(negedge clk);
    idle_inputs();
    out_ready[3] = 1'b0;
    offer(3, 16'h5500, 1'b1);
    #2;
    check(out_valid[3] && !in_ready[3], "R6", "stall blocks input",
          in_ready, 0);
    @(negedge clk);
    offer(1, 16'h6600, 1'b1);
    #2;
    check(out_data[3*W +: W] == 16'h5500 && in_ready == '0, "R6",
          "stalled flit kept", out_data[3*W +: W], 16'h5500);
    @(negedge clk);
    out_ready[3] = 1'b1;
    #2;
    check(out_data[3*W +: W] == 16'h5500 && in_ready == 4'b1000, "R6",
          "stalled flit released", out_data[3*W +: W], 16'h5500);
    @(negedge clk);
    in_valid[3] = 1'b0;
    #2;
    check(out_data[3*W +: W] == 16'h6600 && in_ready[1], "R6",
          "waiting head follows", out_data[3*W +: W], 16'h6600);

    // R7 concurrency
    @(negedge clk);
    idle_inputs();
    offer(0, 16'h7001, 1'b1);
    offer(1, 16'h8002, 1'b1);
    offer(2, 16'h9000, 1'b1);
    #2;
    check(out_valid == 4'b1011 && in_ready == 4'b0111, "R7",
          "parallel forwarding", {in_ready, out_valid}, 8'h7B);
    check(out_data[0 +: W] == 16'h7001 && out_data[W +: W] == 16'h8002 &&
          out_data[3*W +: W] == 16'h9000, "R7", "parallel data",
          out_data, 0);
    @(negedge clk);
    idle_inputs();
    #2;
    check(out_valid == '0, "R8", "idle output", out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule